// File: doc/BRIEF.md
# Lock-Step Banked Sequential Word Reader

This block reads a run of consecutive words from a memory split into several banks, with the word address spread across the banks by its low bits. Every fetch sends one row address to all banks together. All banks take the same fixed number of cycles to answer. Their words land in a set of per-bank holding registers, and a selector then sends those words out one per cycle in bank order. The fetch for the next row starts on a fixed cadence, so the next row arrives in the holding registers as the last word of the current row leaves.

A client waits for `ready`, then presents a start address and a word count for one cycle with `req_valid`. The block sends exactly that many words on `out_valid`/`out_data`, in ascending address order. It then pulses `done` and returns to idle.

The controller has four states:
- IDLE: waiting for a request. A non-zero count moves it to FILL. A zero count moves it straight to DONE.
- FILL: the first row fetch is in flight. It moves to STREAM when the banks' answers are captured.
- STREAM: words are being sent while later rows are fetched. It moves to DONE on the final word.
- DONE: one cycle, after which it returns to IDLE.

Bank contents are seeded at reset with an address-derived pattern. Writing is not part of the block.

Top module: `ilv_seq_reader`

## Requirements
- R1: A word address of ROW_BITS+BANK_BITS bits is decoded as follows: bits [BANK_BITS-1:0] pick the bank and the remaining upper bits pick the row inside it. After reset the word at address A holds the low DATA_W bits of A*0x9E37 + 0x5A5A.
- R2: Every fetch starts all banks in the same cycle on one shared row. Each bank's answer is captured exactly LATENCY cycles after its start. No bank is restarted before its previous access has returned.
- R3: Output words follow ascending addresses from the start address. Addresses wrap modulo 2^(ROW_BITS+BANK_BITS).
- R4: `out_valid` is high for exactly the requested count. A count of zero produces no words and only the `done` pulse, in the cycle after acceptance.
- R5: The first word appears LATENCY+2+b cycles after the acceptance cycle, where b is the start address modulo the bank count. The lower-bank words of that first row are dropped.
- R6: Once the first word appears, the following words come one per clock with no gap. Parameter sets with fewer banks than LATENCY are rejected at elaboration.
- R7: `done` is high for one cycle, in the cycle right after the last word. `ready` is high again in the following cycle.
- R8: `ready` is high only while idle. A `req_valid` seen while `ready` is low is ignored and leaves the running stream unchanged.
- R9: During and right after reset, `ready` is 1 and `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is high |
| req_addr | input | ROW_BITS+BANK_BITS | Start word address |
| req_count | input | CNT_W | Number of words to send |
| ready | output | 1 | Idle and able to take a request |
| out_valid | output | 1 | `out_data` carries a word this cycle |
| out_data | output | DATA_W | Output word |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
Two things can fall in the same cycle: the capture of a newly fetched row into the holding registers, and the sending of the previous row's last word from those same registers. Requests that span several rows provoke this collision. Start offsets 0 to 3 are used so that the collision lands at different distances from the first word, and one request wraps past the top address. A cycle-exact model predicts the valid flag and data word on every clock. If the capture came one cycle early, the last word of each row would show the next row's data. If it came one cycle late, the next row would repeat stale data. Either way the per-word comparison reports the error.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_STREAM,
        ST_DONE
    } ilv_state_e;

    localparam logic [31:0] SEED_MUL = 32'h0000_9E37;
    localparam logic [31:0] SEED_ADD = 32'h0000_5A5A;

    // Reset contents of the word at a flat address (R1)
    function automatic logic [31:0] seed_word(input logic [31:0] flat_addr);
        return flat_addr * SEED_MUL + SEED_ADD;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
`timescale 1ns/1ps
module ilv_bank #(
    parameter int ROW_BITS  = 4,
    parameter int DATA_W    = 16,
    parameter int LATENCY   = 3,
    parameter int BANK_BITS = 2,
    parameter int BANK_IDX  = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ROW_BITS-1:0] row,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data
);
    import ilv_pkg::*;

    localparam int DEPTH = 1 << ROW_BITS;
    localparam int NB    = 1 << BANK_BITS;

    logic [DATA_W-1:0]   mem_q  [DEPTH];
    logic [LATENCY-1:0]  vld_q;
    logic [ROW_BITS-1:0] row_q  [LATENCY];

    // Array seeded at reset; access travels LATENCY stages (R2)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= DATA_W'(seed_word(32'(w * NB + BANK_IDX)));
            end
            vld_q <= '0;
            for (int s = 0; s < LATENCY; s++) begin
                row_q[s] <= '0;
            end
        end else begin
            vld_q[0] <= start;
            row_q[0] <= row;
            for (int s = 1; s < LATENCY; s++) begin
                vld_q[s] <= vld_q[s-1];
                row_q[s] <= row_q[s-1];
            end
        end
    end

    assign rd_valid = vld_q[LATENCY-1];
    assign rd_data  = mem_q[row_q[LATENCY-1]];

endmodule

// File: rtl/ilv_out_stage.sv
`timescale 1ns/1ps
module ilv_out_stage #(
    parameter int NB     = 4,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture,
    input  logic [NB-1:0][DATA_W-1:0] bank_words,
    input  logic [SEL_W-1:0]          sel,
    output logic [DATA_W-1:0]         word
);
    logic [DATA_W-1:0] hold_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[g] <= '0;
            end else if (capture) begin
                hold_q[g] <= bank_words[g];
            end
        end
    end

    assign word = hold_q[sel];

endmodule

// File: rtl/ilv_seq_reader.sv
`timescale 1ns/1ps
module ilv_seq_reader #(
    parameter int ROW_BITS  = 4,
    parameter int BANK_BITS = 2,
    parameter int DATA_W    = 16,
    parameter int LATENCY   = 3,
    parameter int CNT_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [ROW_BITS+BANK_BITS-1:0]   req_addr,
    input  logic [CNT_W-1:0]                req_count,
    output logic                            ready,
    output logic                            out_valid,
    output logic [DATA_W-1:0]               out_data,
    output logic                            done
);
    import ilv_pkg::*;

    localparam int ADDR_W = ROW_BITS + BANK_BITS;
    localparam int NB     = 1 << BANK_BITS;
    localparam int SPAN_W = CNT_W + 2;

    // R6: one word per clock needs at least LATENCY banks
    if (NB < LATENCY || LATENCY < 1) begin : g_param_chk
        $error("ilv_seq_reader: bank count must be >= LATENCY >= 1");
    end

    ilv_state_e state_q, state_d;

    logic [BANK_BITS-1:0]      phase_q;
    logic [BANK_BITS-1:0]      out_idx_q;
    logic [BANK_BITS-1:0]      skip_q;
    logic                      first_row_q;
    logic [SPAN_W-1:0]         rows_left_q;
    logic [ROW_BITS-1:0]       row_ptr_q;
    logic [CNT_W-1:0]          words_left_q;

    logic                      accept;
    logic                      fetching;
    logic                      bank_start;
    logic                      out_fire;
    logic                      capture;
    logic [NB-1:0]             bank_vld;
    logic [NB-1:0][DATA_W-1:0] bank_data;
    logic [SPAN_W-1:0]         span;

    // Banks share one row and one start strobe (R1, R2)
    for (genvar g = 0; g < NB; g++) begin : g_bank
        ilv_bank #(
            .ROW_BITS (ROW_BITS),
            .DATA_W   (DATA_W),
            .LATENCY  (LATENCY),
            .BANK_BITS(BANK_BITS),
            .BANK_IDX (g)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (bank_start),
            .row     (row_ptr_q),
            .rd_valid(bank_vld[g]),
            .rd_data (bank_data[g])
        );
    end

    assign capture = &bank_vld;

    ilv_out_stage #(
        .NB    (NB),
        .SEL_W (BANK_BITS),
        .DATA_W(DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .bank_words(bank_data),
        .sel       (out_idx_q),
        .word      (out_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = (req_count == '0) ? ST_DONE : ST_FILL;
            ST_FILL:   if (capture) state_d = ST_STREAM;
            ST_STREAM: if (out_fire && words_left_q == CNT_W'(1)) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and strobes
    always_comb begin
        ready      = (state_q == ST_IDLE);
        done       = (state_q == ST_DONE);
        accept     = ready && req_valid;
        fetching   = (state_q == ST_FILL) || (state_q == ST_STREAM);
        bank_start = fetching && (phase_q == '0) && (rows_left_q != '0);
        out_fire   = (state_q == ST_STREAM) && (words_left_q != '0)
                     && !(first_row_q && (out_idx_q < skip_q));
        out_valid  = out_fire;
        span       = SPAN_W'(req_addr[BANK_BITS-1:0]) + SPAN_W'(req_count)
                     + SPAN_W'(NB - 1);
    end

    // Datapath counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= '0;
            out_idx_q    <= '0;
            skip_q       <= '0;
            first_row_q  <= 1'b0;
            rows_left_q  <= '0;
            row_ptr_q    <= '0;
            words_left_q <= '0;
        end else begin
            if (accept) begin
                phase_q      <= '0;
                skip_q       <= req_addr[BANK_BITS-1:0];
                row_ptr_q    <= req_addr[ADDR_W-1:BANK_BITS];
                words_left_q <= req_count;
                rows_left_q  <= span >> BANK_BITS;
            end else begin
                if (fetching) begin
                    phase_q <= phase_q + 1'b1;
                end
                if (bank_start) begin
                    rows_left_q <= rows_left_q - 1'b1;
                    row_ptr_q   <= row_ptr_q + 1'b1;
                end
                if (out_fire) begin
                    words_left_q <= words_left_q - 1'b1;
                end
            end
            if (state_q == ST_FILL && capture) begin
                out_idx_q   <= '0;
                first_row_q <= 1'b1;
            end else if (state_q == ST_STREAM) begin
                out_idx_q <= out_idx_q + 1'b1;
                if (out_idx_q == BANK_BITS'(NB - 1)) begin
                    first_row_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/ilv_seq_reader_chk.sv
`timescale 1ns/1ps
module ilv_seq_reader_chk #(
    parameter int LATENCY = 3
) (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic out_valid,
    input logic done,
    input logic bank_start,
    input logic capture
);
    logic [7:0] since_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (bank_start) begin
            since_q <= 8'd1;
            seen_q  <= 1'b1;
        end else if (since_q != 8'hFF) begin
            since_q <= since_q + 8'd1;
        end
    end

    // R2
    bank_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_start && seen_q) |-> (since_q >= 8'(LATENCY)));

    // R2
    bank_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (seen_q && since_q == 8'(LATENCY)));

    // R8
    valid_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !ready);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);

    // R4
    done_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

endmodule

bind ilv_seq_reader ilv_seq_reader_chk #(.LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .out_valid (out_valid),
    .done      (done),
    .bank_start(bank_start),
    .capture   (capture)
);

// File: tb/ilv_seq_reader_tb_top.sv
`timescale 1ns/1ps
module ilv_seq_reader_tb_top;

    localparam int RB  = 4;
    localparam int BB  = 2;
    localparam int DW  = 16;
    localparam int LAT = 3;
    localparam int CW  = 8;
    localparam int AW  = RB + BB;
    localparam int NB  = 1 << BB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_count = '0;
    logic          ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          done;

    always #5 clk = ~clk;

    ilv_seq_reader #(
        .ROW_BITS (RB),
        .BANK_BITS(BB),
        .DATA_W   (DW),
        .LATENCY  (LAT),
        .CNT_W    (CW)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_count(req_count),
        .ready    (ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .done     (done)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // R1: expected content of flat address A
    function automatic int exp_word(input int a);
        int aa;
        aa = a % (1 << AW);
        return (aa * 40503 + 23130) % 65536;
    endfunction

    always @(posedge clk) cyc = cyc + 1;

    // Reference model, compared every cycle
    bit m_busy = 1'b0;
    int m_start, m_cnt, m_first, m_done;
    int obs_n, obs_first, obs_last;

    always @(negedge clk) begin
        if (!rst_n) begin
            // R9
            chk(ready == 1'b1, "R9 ready in reset", int'(ready), 1);
            chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
            chk(done == 1'b0, "R9 done in reset", int'(done), 0);
        end else if (!finished) begin
            bit e_ready, e_valid, e_done;
            e_ready = !m_busy;
            e_valid = m_busy && m_cnt > 0 && cyc >= m_first && cyc < m_first + m_cnt;
            e_done  = m_busy && cyc == m_done;
            chk(ready == e_ready, "R8 ready", int'(ready), int'(e_ready));
            chk(out_valid == e_valid, "R5 R6 R8 out_valid timing", int'(out_valid), int'(e_valid));
            chk(done == e_done, "R7 done timing", int'(done), int'(e_done));
            if (e_valid && out_valid) begin
                chk(int'(out_data) == exp_word(m_start + cyc - m_first),
                    "R1 R2 R3 word value", int'(out_data), exp_word(m_start + cyc - m_first));
            end
            if (m_busy && out_valid) begin
                if (obs_n == 0) obs_first = cyc;
                obs_last = cyc;
                obs_n++;
            end
            if (e_done) begin
                chk(obs_n == m_cnt, "R4 word count", obs_n, m_cnt);
                if (m_cnt > 0) begin
                    chk(obs_last - obs_first + 1 == m_cnt, "R6 no gaps",
                        obs_last - obs_first + 1, m_cnt);
                end
                m_busy = 1'b0;
            end else if (e_ready && req_valid) begin
                m_busy  = 1'b1;
                m_start = int'(req_addr);
                m_cnt   = int'(req_count);
                m_first = cyc + LAT + 2 + (int'(req_addr) % NB);
                m_done  = (m_cnt == 0) ? cyc + 1 : m_first + m_cnt;
                obs_n   = 0;
            end
        end
    end

    task automatic wait_idle();
        @(posedge clk); #1;
        while (!ready) begin
            @(posedge clk); #1;
        end
    endtask

    // Issue one request; optionally drive ignored strobes while busy (R8)
    task automatic issue(input int a, input int c, input bit noise);
        wait_idle();
        req_valid = 1'b1;
        req_addr  = AW'(a);
        req_count = CW'(c);
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (noise) begin
            repeat (5) @(posedge clk);
            #1;
            req_valid = 1'b1;
            req_addr  = AW'(33);
            req_count = CW'(2);
            repeat (3) @(posedge clk);
            #1;
            req_valid = 1'b0;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        issue(0, 8, 1'b0);     // R3 R5: aligned, two rows
        issue(5, 7, 1'b0);     // R5: offset 1
        issue(3, 1, 1'b0);     // R5: offset 3, single word
        issue(62, 6, 1'b0);    // R3: wrap past top address
        issue(0, 0, 1'b0);     // R4: zero count
        issue(10, 64, 1'b1);   // R6 R8: long run with ignored strobes
        issue(7, 4, 1'b0);     // R7: back-to-back after ready
        issue(2, 13, 1'b0);    // R2: several row captures with offset 2
        wait_idle();
        repeat (4) @(posedge clk);
        #1;
        chk(m_busy == 1'b0, "R7 model idle at end", int'(m_busy), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule